// File: doc/BRIEF.md
# Receive Elastic Buffer with Fill Status

This block sits between a receiver that delivers symbols on a recovered clock and logic that consumes them on a local user clock. Symbols are written on the recovered-clock side and read on the user-clock side. Each side keeps its own pointer, and each pointer crosses to the other side as a Gray code through a two-stage synchronizer. Each side works out the fill level from its own pointer and the synchronized copy of the other pointer. After any reset the buffer holds half its depth in zero-valued filler entries. This gives both clocks the same headroom to drift in either direction.

On the read side a 3-bit status code reports the fill level against two latency thresholds, and it also reports overflow or underflow. An overflow or underflow makes the buffered contents invalid. That error stays latched until the buffer-reset input is pulsed. A static width select decides whether 8 or 10 bits of each symbol are kept.

Back-pressure rules: the writer is never stalled, because the buffer has no ready signal toward the write side. A write into a full buffer is an overflow. On the read side, `rd_valid` shows that a symbol is at the head, and a symbol is consumed on each rising edge of `rd_clk` where both `rd_valid` and `rd_ready` are high. When `rd_ready` is low the head and the fill level stay put. When `rd_ready` is high while the buffer is empty, the read is an underflow.

Top module: `rx_elastic_buf`

## Requirements
- R1: `status` takes only the values 000, 001, 010, 101 or 110. It reads 000 when no error is latched and the read-side fill level lies between MIN_LAT and MAX_LAT, both ends included.
- R2: With no error latched, `status` is 001 when the read-side fill level is below MIN_LAT (default 4).
- R3: With no error latched, `status` is 010 when the read-side fill level is above MAX_LAT (default 12). A completely full buffer (16 entries) reports 010.
- R4: When `rd_ready` is high while the buffer is empty and no error is latched, an underflow is latched and `status` becomes 110. Later writes do not clear it.
- R5: A write arriving while the buffer holds DEPTH entries is an overflow. The write is dropped, the overflow is latched, and `status` becomes 101. Overflow takes precedence over underflow, and an error, once latched, remains until a reset.
- R6: Asserting `buf_rst` or `rst_n` reinitializes both sides. Afterwards `status` is 000, `rd_valid` is 1, and the buffer holds DEPTH/2 entries of zero.
- R7: While an error is latched, `rd_valid` is 0 and `rd_data` is all zero.
- R8: With `width_sel` at 0, bits [9:8] of every stored symbol are forced to zero and bits [7:0] are kept. With `width_sel` at 1, all 10 bits are kept. `width_sel` may change only while a reset is applied.
- R9: Symbols come out in write order, after the reset filler. This holds with one write and one read in every cycle.
- R10: While `rd_ready` is low, `rd_data` stays unchanged and writes alone decide the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset for both sides, asynchronous assertion |
| buf_rst | input | 1 | Active-high buffer reinitialize, asynchronous assertion |
| width_sel | input | 1 | Static symbol width: 0 keeps 8 bits, 1 keeps 10 bits |
| wr_clk | input | 1 | Recovered (write-side) clock |
| wr_valid | input | 1 | A symbol is written on this write clock edge |
| wr_data | input | 10 | Symbol to write |
| rd_clk | input | 1 | Local user (read-side) clock |
| rd_ready | input | 1 | Consumer takes the head symbol this cycle |
| rd_valid | output | 1 | Head symbol present and buffer not in error |
| rd_data | output | 10 | Head symbol, zero when not valid |
| status | output | 3 | Fill / error code, synchronous to rd_clk |

## Verification
The bench resets the buffer and moves it to every fill level from empty to full. At each level it compares the status code with the value computed from the thresholds, so a design with an off-by-one compare would fail at 3/4 or 12/13, and a design with a wrong full test would raise overflow at 16 entries. Underflow is provoked by one extra read past empty, and overflow by a seventeenth stored symbol. The bench then confirms that both errors stay latched through later traffic and that only a reset clears them. A design that lost the latch, or that ranked underflow above overflow, would show the wrong code. Streaming with a write and a read in every cycle, done in both widths, exposes filler-count errors, wrong ordering and missing masking of bits [9:8].

// File: rtl/rxeb_pkg.sv
package rxeb_pkg;
  localparam int SYM_W    = 10;
  localparam int NARROW_W = 8;

  typedef enum logic [2:0] {
    ST_NOMINAL = 3'b000,
    ST_LOW     = 3'b001,
    ST_HIGH    = 3'b010,
    ST_OVF     = 3'b101,
    ST_UNF     = 3'b110
  } eb_status_e;
endpackage

// File: rtl/rxeb_sync.sv
// Two-stage synchronizer, reset to a chosen value.
module rxeb_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rxeb_mem.sv
// Storage: write on the write clock, asynchronous read by the read side.
module rxeb_mem #(
  parameter int AW = 4,
  parameter int DW = 10
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rxeb_wr_ctl.sv
// Write side: pointer, full detection, sticky overflow.
module rxeb_wr_ctl #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [AW:0] rgray_s,
  output logic        we,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  output logic        ovf
);
  localparam int        PW    = AW + 1;
  localparam int        DEPTH = 1 << AW;
  localparam logic [PW-1:0] HALF   = PW'(DEPTH / 2);
  localparam logic [PW-1:0] HALF_G = HALF ^ (HALF >> 1);

  logic [PW-1:0] wbin, wbin_nx, rbin, fill;
  logic          full;

  always_comb begin
    rbin[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_s[i];
  end

  assign fill    = wbin - rbin;
  assign full    = (fill == PW'(DEPTH));
  assign we      = wr_valid && !full && !ovf;
  assign waddr   = wbin[AW-1:0];
  assign wbin_nx = wbin + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= HALF;
      wgray <= HALF_G;
      ovf   <= 1'b0;
    end else begin
      if (wr_valid && (full || ovf)) ovf <= 1'b1;
      if (we) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end
endmodule

// File: rtl/rxeb_rd_ctl.sv
// Read side: pointer, fill level, sticky underflow, status code.
module rxeb_rd_ctl
  import rxeb_pkg::*;
#(
  parameter int AW      = 4,
  parameter int MIN_LAT = 4,
  parameter int MAX_LAT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ready,
  input  logic [AW:0]   wgray_s,
  input  logic          ovf_s,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          rd_valid,
  output eb_status_e    status
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nx, wbin, fill;
  logic          unf, err, empty, take;

  always_comb begin
    wbin[PW-1] = wgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_s[i];
  end

  assign fill     = wbin - rbin;
  assign empty    = (fill == '0);
  assign err      = ovf_s || unf;
  assign rd_valid = !err && !empty;
  assign take     = rd_ready && rd_valid;
  assign raddr    = rbin[AW-1:0];
  assign rbin_nx  = rbin + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      unf   <= 1'b0;
    end else begin
      if (rd_ready && empty && !err) unf <= 1'b1;
      if (take) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
    end
  end

  always_comb begin
    if (ovf_s)                     status = ST_OVF;
    else if (unf)                  status = ST_UNF;
    else if (fill < PW'(MIN_LAT))  status = ST_LOW;
    else if (fill > PW'(MAX_LAT))  status = ST_HIGH;
    else                           status = ST_NOMINAL;
  end
endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
  import rxeb_pkg::*;
#(
  parameter int AW      = 4,
  parameter int MIN_LAT = 4,
  parameter int MAX_LAT = 12
) (
  input  logic             rst_n,
  input  logic             buf_rst,
  input  logic             width_sel,
  input  logic             wr_clk,
  input  logic             wr_valid,
  input  logic [SYM_W-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [SYM_W-1:0] rd_data,
  output logic [2:0]       status
);
  localparam int        PW     = AW + 1;
  localparam int        DEPTH  = 1 << AW;
  localparam logic [PW-1:0] HALF   = PW'(DEPTH / 2);
  localparam logic [PW-1:0] HALF_G = HALF ^ (HALF >> 1);

  // Reset per domain: asynchronous assertion, synchronized release.
  logic       any_rst_n;
  logic [1:0] wrs, rrs;
  assign any_rst_n = rst_n && !buf_rst;

  always_ff @(posedge wr_clk or negedge any_rst_n) begin
    if (!any_rst_n) wrs <= 2'b00;
    else            wrs <= {wrs[0], 1'b1};
  end

  always_ff @(posedge rd_clk or negedge any_rst_n) begin
    if (!any_rst_n) rrs <= 2'b00;
    else            rrs <= {rrs[0], 1'b1};
  end

  logic             we, ovf, ovf_s, vld;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
  logic [SYM_W-1:0] wdata_m, mem_q;
  eb_status_e       st;

  assign wdata_m = width_sel ? wr_data
                             : {{(SYM_W-NARROW_W){1'b0}}, wr_data[NARROW_W-1:0]};

  rxeb_wr_ctl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wrs[1]), .wr_valid(wr_valid), .rgray_s(rgray_s),
    .we(we), .waddr(waddr), .wgray(wgray), .ovf(ovf)
  );

  rxeb_mem #(.AW(AW), .DW(SYM_W)) u_mem (
    .wclk(wr_clk), .wrst_n(wrs[1]), .we(we), .waddr(waddr), .wdata(wdata_m),
    .raddr(raddr), .rdata(mem_q)
  );

  rxeb_sync #(.W(PW), .RST_VAL(HALF_G)) u_w2r (
    .clk(rd_clk), .rst_n(rrs[1]), .d(wgray), .q(wgray_s)
  );

  rxeb_sync #(.W(PW), .RST_VAL('0)) u_r2w (
    .clk(wr_clk), .rst_n(wrs[1]), .d(rgray), .q(rgray_s)
  );

  rxeb_sync #(.W(1), .RST_VAL(1'b0)) u_ovf (
    .clk(rd_clk), .rst_n(rrs[1]), .d(ovf), .q(ovf_s)
  );

  rxeb_rd_ctl #(.AW(AW), .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT)) u_rd (
    .clk(rd_clk), .rst_n(rrs[1]), .rd_ready(rd_ready), .wgray_s(wgray_s),
    .ovf_s(ovf_s), .raddr(raddr), .rgray(rgray), .rd_valid(vld), .status(st)
  );

  assign rd_valid = vld;
  assign rd_data  = vld ? mem_q : '0;
  assign status   = st;
endmodule

// File: rtl/rx_elastic_buf_chk.sv
module rx_elastic_buf_chk (
  input logic       rd_clk,
  input logic       rst_n,
  input logic       buf_rst,
  input logic       width_sel,
  input logic       rd_ready,
  input logic       rd_valid,
  input logic [9:0] rd_data,
  input logic [2:0] status
);
  p_legal_code_r1: assert property (@(posedge rd_clk) disable iff (!rst_n || buf_rst)
    status inside {3'b000, 3'b001, 3'b010, 3'b101, 3'b110});

  p_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n || buf_rst)
    (rd_ready && !rd_valid && !status[2]) |=> (status == 3'b110 || status == 3'b101));

  p_sticky_err_r5: assert property (@(posedge rd_clk) disable iff (!rst_n || buf_rst)
    status[2] |=> status[2]);

  p_quiet_on_err_r7: assert property (@(posedge rd_clk) disable iff (!rst_n || buf_rst)
    status[2] |-> (!rd_valid && rd_data == 10'd0));

  p_narrow_r8: assert property (@(posedge rd_clk) disable iff (!rst_n || buf_rst)
    (!width_sel && rd_valid) |-> rd_data[9:8] == 2'b00);

  p_hold_r10: assert property (@(posedge rd_clk) disable iff (!rst_n || buf_rst)
    (rd_valid && !rd_ready) |=> (!rd_valid || $stable(rd_data)));
endmodule

bind rx_elastic_buf rx_elastic_buf_chk u_chk (
  .rd_clk(rd_clk), .rst_n(rst_n), .buf_rst(buf_rst), .width_sel(width_sel),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .status(status)
);

// File: tb/rx_elastic_buf_test.sv
module rx_elastic_buf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, buf_rst = 1'b0, width_sel = 1'b1;
  logic       wr_valid = 1'b0, rd_ready = 1'b0;
  logic [9:0] wr_data = '0;
  logic       rd_valid;
  logic [9:0] rd_data;
  logic [2:0] status;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz, both sides share it

  rx_elastic_buf uut (
    .rst_n(rst_n), .buf_rst(buf_rst), .width_sel(width_sel),
    .wr_clk(clk), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_clk(clk), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .status(status)
  );

  function automatic int val(input int i);
    return (i * 37 + 5) % 1024;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reinit(input logic ws);
    @(negedge clk);
    buf_rst = 1'b1; width_sel = ws; wr_valid = 1'b0; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    buf_rst = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic put(input int n, input int base);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_data = 10'(val(base + k));
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic take(input int n, input bit zero_chk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (zero_chk) chk("R6 filler data", int'(rd_data), 0);
      rd_ready = 1'b1;
    end
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic stream(input logic ws);
    int mask;
    mask = ws ? 1023 : 255;
    reinit(ws);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      chk("R9 stream valid", int'(rd_valid), 1);
      if (i < 8) chk("R9 filler", int'(rd_data), 0);
      else       chk(ws ? "R9 data wide" : "R8 data narrow", int'(rd_data), val(i - 8) & mask);
      wr_valid = 1'b1; wr_data = 10'(val(i)); rd_ready = 1'b1;
    end
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0;
    settle();
    chk("R1 stream status", int'(status), 0);
  endtask

  initial begin
    int exp_st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 reset status", int'(status), 0);
    chk("R6 reset valid", int'(rd_valid), 1);
    chk("R6 reset data", int'(rd_data), 0);

    // Sweep every fill level
    for (int n = 0; n <= 16; n++) begin
      reinit(1'b1);
      if (n > 8) put(n - 8, 100);
      if (n < 8) take(8 - n, 1'b1);
      settle();
      exp_st = (n < 4) ? 1 : (n > 12) ? 2 : 0;
      chk(n < 4 ? "R2 low fill" : n > 12 ? "R3 high fill" : "R1 nominal fill",
          int'(status), exp_st);
      chk("R1 valid vs fill", int'(rd_valid), (n != 0) ? 1 : 0);
    end

    // Underflow
    reinit(1'b1);
    take(9, 1'b0);
    settle();
    chk("R4 underflow code", int'(status), 6);
    chk("R7 valid low", int'(rd_valid), 0);
    chk("R7 data zero", int'(rd_data), 0);
    put(3, 200);
    settle();
    chk("R4 underflow sticky", int'(status), 6);
    chk("R7 valid still low", int'(rd_valid), 0);
    reinit(1'b1);
    chk("R6 clear after underflow", int'(status), 0);

    // Overflow
    reinit(1'b1);
    put(9, 300);
    settle();
    chk("R5 overflow code", int'(status), 5);
    chk("R7 valid low ovf", int'(rd_valid), 0);
    chk("R7 data zero ovf", int'(rd_data), 0);
    take(2, 1'b0);
    put(2, 400);
    settle();
    chk("R5 overflow sticky and first", int'(status), 5);
    reinit(1'b1);
    chk("R6 clear after overflow", int'(status), 0);
    chk("R6 valid after overflow", int'(rd_valid), 1);

    // Exactly full is not overflow, then a drain shows what was kept
    reinit(1'b1);
    put(8, 500);
    settle();
    chk("R3 full not overflow", int'(status), 2);
    take(8, 1'b1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R9 drain order", int'(rd_data), val(500 + k));
      rd_ready = 1'b1;
    end
    @(negedge clk);
    rd_ready = 1'b0;
    settle();
    chk("R2 drained empty", int'(status), 1);
    chk("R1 empty invalid", int'(rd_valid), 0);

    // Back-pressure: no reads, head stable, writes raise fill
    reinit(1'b1);
    take(1, 1'b0);
    @(negedge clk);
    chk("R10 head filler", int'(rd_data), 0);
    put(6, 600);  // fill 7 + 6 = 13
    settle();
    chk("R10 fill from writes", int'(status), 2);
    repeat (5) @(negedge clk);
    chk("R10 head held", int'(rd_data), 0);
    chk("R10 valid held", int'(rd_valid), 1);

    // Streaming in both widths
    stream(1'b1);
    stream(1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule